// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits between raw interrupt pins and a downstream interrupt controller. It watches one non-maskable input and a parameterised set of sixteen request inputs. Each pin is brought into the clock domain through two flops, then compared with its previous sample to find edges. Each request channel has its own two-bit sense code. The non-maskable input can be set to catch either its falling or its rising edge. Every channel holds a status flag and drives an active-high level toward the downstream controller for as long as that flag is set.

Software reaches the block over a minimal 32-bit register port: address, write strobe, write data and combinational read data. It sets the sense codes, reads the flags, and clears edge-captured flags by writing ones to a clear location. In low-level mode a flag is not captured. It mirrors the inverted pin, so writes to the clear location do nothing to it. Pins idle high, and the synchronizers reset to that idle level.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset all status flags, the request sense register (0x18), the non-maskable sense bit (0x08) and both interrupt outputs read 0.
- R2: The request sense register at offset 0x18 holds channel n's code in bits [2n+1:2n], reads back what was written, and changes only on a write to 0x18.
- R3: Sense code 1 (falling) sets channel n's flag on a high-to-low pin change and never on a low-to-high change.
- R4: Sense code 2 (rising) sets the flag on a low-to-high pin change and never on a high-to-low change.
- R5: Sense code 3 (both) sets the flag on either pin transition.
- R6: Sense code 0 (low level) makes the flag equal to the inverted synchronized pin; writes to the clear location have no effect on it.
- R7: In an edge mode, writing 1 to bit n of offset 0x14 clears request flag n; zero bits leave other flags untouched. The request flags read at offset 0x10, bit n.
- R8: An edge that arrives in the same cycle as a clear write for that channel leaves the flag set.
- R9: Bit 0 of offset 0x08 selects the non-maskable edge (0 falling, 1 rising); its flag reads at offset 0x00, bit 0.
- R10: Writing 1 to bit 0 of offset 0x04 clears the non-maskable flag.
- R11: Each output (irq_out[n], nmi_out) is high exactly while its flag is set.
- R12: Reads of any offset other than 0x00, 0x08, 0x10 and 0x18 return 0, and writes to unmapped offsets change no state.
- R13: A pin change is reflected in the flag on the third rising clock edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| irq_pin | input | N_IRQ (16) | Asynchronous request pins |
| addr | input | ADDR_W (12) | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| nmi_out | output | 1 | Level output of the non-maskable flag |
| irq_out | output | N_IRQ (16) | Level outputs of the request flags |

## Verification
The bench drives the opposite edge in each single-edge mode. A detector with swapped polarity, or one that fires on any change, would set a flag there. It issues a clear write in exactly the cycle that a new edge is seen. A design that lets the clear win would lose that interrupt. It also writes to a low-level channel's clear bit while the pin is held low, to catch a design that treats level flags as captured. The bench samples one cycle before and one cycle at the expected flag update, which exposes a missing or extra synchronizer stage. It writes to unmapped offsets and then reads the real registers, which exposes loose address decoding.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  localparam int OFF_NMI_STAT  = 'h00;
  localparam int OFF_NMI_CLR   = 'h04;
  localparam int OFF_NMI_SENSE = 'h08;
  localparam int OFF_IRQ_STAT  = 'h10;
  localparam int OFF_IRQ_CLR   = 'h14;
  localparam int OFF_IRQ_SENSE = 'h18;

  // Edge event for a request channel given its sense code.
  function automatic logic irq_edge_hit(sense_e mode, logic prev, logic cur);
    logic hit;
    case (mode)
      SENSE_FALL: hit = prev & ~cur;
      SENSE_RISE: hit = ~prev & cur;
      SENSE_BOTH: hit = prev ^ cur;
      default:    hit = 1'b0;
    endcase
    return hit;
  endfunction

  // Edge event for the non-maskable channel.
  function automatic logic nmi_edge_hit(logic want_rise, logic prev, logic cur);
    return want_rise ? (~prev & cur) : (prev & ~cur);
  endfunction

  // Extract channel n's sense code from a packed sense vector.
  function automatic sense_e sense_at(logic [31:0] vec, int n);
    return sense_e'(vec[2*n +: 2]);
  endfunction

endpackage

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
module extint_sync #(
  parameter int   W       = 1,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= IDLE_LVL;
        stab_q <= IDLE_LVL;
      end else begin
        meta_q <= d_async[i];
        stab_q <= meta_q;
      end
    end
    assign d_sync[i] = stab_q;
  end

endmodule

// File: rtl/extint_irq_chan.sv
`timescale 1ns/1ps
module extint_irq_chan
  import extint_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode,
  input  logic   pin_s,
  input  logic   clr,
  output logic   flag,
  output logic   evt
);

  logic prev_q;
  logic lvl_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= pin_s;
  end

  assign evt      = irq_edge_hit(mode, prev_q, pin_s);
  assign lvl_mode = (mode == SENSE_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (lvl_mode) flag <= ~pin_s;
    else if (evt)      flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  // R6: level mode follows the pin regardless of clear
  assert_lvl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && !pin_s) |=> flag);
  assert_lvl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && pin_s) |=> !flag);
  // R8: an edge wins over a concurrent clear
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && evt) |=> flag);
  // R7: clear without edge drops the flag
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && clr && !evt) |=> !flag);
  // R3: no spontaneous set in edge modes
  assert_no_spont_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_mode && !evt && !flag) |=> !flag);

endmodule

// File: rtl/extint_nmi_chan.sv
`timescale 1ns/1ps
module extint_nmi_chan
  import extint_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_rise,
  input  logic pin_s,
  input  logic clr,
  output logic flag,
  output logic evt
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= pin_s;
  end

  assign evt = nmi_edge_hit(want_rise, prev_q, pin_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R9: selected edge sets the flag
  assert_nmi_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  // R10: clear without edge drops the flag
  assert_nmi_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag);
  // R9: flag holds when nothing happens
  assert_nmi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !evt) |=> (flag == $past(flag)));

endmodule

// File: rtl/extint_regs.sv
`timescale 1ns/1ps
module extint_regs
  import extint_pkg::*;
#(
  parameter int N_IRQ  = 16,
  parameter int ADDR_W = 12,
  localparam int SENSE_W = 2 * N_IRQ
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  input  logic [N_IRQ-1:0]   irq_flags,
  input  logic               nmi_flag,
  output logic [SENSE_W-1:0] irq_sense,
  output logic               nmi_rise,
  output logic [N_IRQ-1:0]   irq_clr,
  output logic               nmi_clr,
  output logic [31:0]        rdata
);

  logic sel_nmi_stat, sel_nmi_clr, sel_nmi_sense;
  logic sel_irq_stat, sel_irq_clr, sel_irq_sense;
  logic read_hit;

  assign sel_nmi_stat  = (addr == ADDR_W'(OFF_NMI_STAT));
  assign sel_nmi_clr   = (addr == ADDR_W'(OFF_NMI_CLR));
  assign sel_nmi_sense = (addr == ADDR_W'(OFF_NMI_SENSE));
  assign sel_irq_stat  = (addr == ADDR_W'(OFF_IRQ_STAT));
  assign sel_irq_clr   = (addr == ADDR_W'(OFF_IRQ_CLR));
  assign sel_irq_sense = (addr == ADDR_W'(OFF_IRQ_SENSE));
  assign read_hit      = sel_nmi_stat | sel_nmi_sense | sel_irq_stat | sel_irq_sense;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sense <= '0;
      nmi_rise  <= 1'b0;
    end else if (wr_en) begin
      if (sel_irq_sense) irq_sense <= wdata[SENSE_W-1:0];
      if (sel_nmi_sense) nmi_rise  <= wdata[0];
    end
  end

  assign irq_clr = (wr_en && sel_irq_clr) ? wdata[N_IRQ-1:0] : '0;
  assign nmi_clr = wr_en && sel_nmi_clr && wdata[0];

  always_comb begin
    rdata = 32'd0;
    if (sel_nmi_stat)  rdata = {31'd0, nmi_flag};
    if (sel_nmi_sense) rdata = {31'd0, nmi_rise};
    if (sel_irq_stat)  rdata = 32'(irq_flags);
    if (sel_irq_sense) rdata = 32'(irq_sense);
  end

  // R12: unmapped reads return zero
  always_comb begin
    if (!read_hit) assert_unmapped_zero_R12: assert (rdata == 32'd0);
  end

  // R2: sense register only moves on a write to its own offset
  assert_sense_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel_irq_sense) |=> $stable(irq_sense));
  // R12: non-maskable sense bit only moves on its own write
  assert_nmi_sense_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel_nmi_sense) |=> $stable(nmi_rise));

endmodule

// File: rtl/extint_sense_ctrl.sv
`timescale 1ns/1ps
module extint_sense_ctrl
  import extint_pkg::*;
#(
  parameter int   N_IRQ    = 16,
  parameter int   ADDR_W   = 12,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic [N_IRQ-1:0]  irq_pin,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              nmi_out,
  output logic [N_IRQ-1:0]  irq_out
);

  localparam int SENSE_W = 2 * N_IRQ;

  logic [N_IRQ-1:0]   irq_s;
  logic               nmi_s;
  logic [SENSE_W-1:0] irq_sense;
  logic               nmi_rise;
  logic [N_IRQ-1:0]   irq_clr;
  logic               nmi_clr;
  logic [N_IRQ-1:0]   irq_flags;
  logic [N_IRQ-1:0]   irq_evt;
  logic               nmi_flag;
  logic               nmi_evt;

  extint_sync #(.W(N_IRQ + 1), .IDLE_LVL(IDLE_LVL)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({nmi_pin, irq_pin}),
    .d_sync  ({nmi_s, irq_s})
  );

  extint_regs #(.N_IRQ(N_IRQ), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .irq_flags (irq_flags),
    .nmi_flag  (nmi_flag),
    .irq_sense (irq_sense),
    .nmi_rise  (nmi_rise),
    .irq_clr   (irq_clr),
    .nmi_clr   (nmi_clr),
    .rdata     (rdata)
  );

  for (genvar n = 0; n < N_IRQ; n++) begin : g_irq
    extint_irq_chan #(.IDLE_LVL(IDLE_LVL)) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (sense_at(32'(irq_sense), n)),
      .pin_s (irq_s[n]),
      .clr   (irq_clr[n]),
      .flag  (irq_flags[n]),
      .evt   (irq_evt[n])
    );
  end

  extint_nmi_chan #(.IDLE_LVL(IDLE_LVL)) u_nmi (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_rise (nmi_rise),
    .pin_s     (nmi_s),
    .clr       (nmi_clr),
    .flag      (nmi_flag),
    .evt       (nmi_evt)
  );

  assign irq_out = irq_flags;
  assign nmi_out = nmi_flag;

  // R11: an output rises only after a detected edge or in level mode
  assert_out_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_out) |-> $past(nmi_evt));

endmodule

// File: tb/sim_extint_sense_ctrl.sv
`timescale 1ns/1ps
module sim_extint_sense_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_pin = 1'b1;
  logic [15:0] irq_pin = 16'hFFFF;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        nmi_out;
  logic [15:0] irq_out;

  int total = 0;
  int bad = 0;
  logic [31:0] sense_exp = 32'd0;

  always #4 clk = ~clk;

  extint_sense_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .nmi_out(nmi_out), .irq_out(irq_out)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    rd(12'h10, v); chk("R1 irq status", v, 0);
    rd(12'h00, v); chk("R1 nmi status", v, 0);
    rd(12'h18, v); chk("R1 irq sense", v, 0);
    rd(12'h08, v); chk("R1 nmi sense", v, 0);
    chk("R1 outputs", {15'd0, nmi_out, irq_out}, 0);
  endtask

  task automatic t_sense_regs;
    logic [31:0] v;
    // ch0 fall, ch1 rise, ch2 both, ch3 low, ch15 rise
    sense_exp = 32'd1 | (32'd2 << 2) | (32'd3 << 4) | (32'd2 << 30);
    wr(12'h18, sense_exp);
    rd(12'h18, v); chk("R2 sense readback", v, sense_exp);
    tick(3);
    rd(12'h10, v); chk("R2 no flags after mode change", v, 0);
  endtask

  task automatic t_fall;
    logic [31:0] v;
    irq_pin[0] = 1'b0;
    tick(2);
    rd(12'h10, v); chk("R13 not yet at 2nd edge", v, 0);
    tick(1);
    rd(12'h10, v); chk("R3 falling sets flag", v, 32'h1);
    chk("R11 irq_out follows flag", 32'(irq_out), 32'h1);
    wr(12'h14, 32'h1);
    rd(12'h10, v); chk("R7 clear edge flag", v, 0);
    chk("R11 irq_out cleared", 32'(irq_out), 0);
    irq_pin[0] = 1'b1;
    tick(4);
    rd(12'h10, v); chk("R3 rising ignored in fall mode", v, 0);
  endtask

  task automatic t_rise;
    logic [31:0] v;
    irq_pin[1] = 1'b0;
    tick(4);
    rd(12'h10, v); chk("R4 falling ignored in rise mode", v, 0);
    irq_pin[1] = 1'b1;
    tick(3);
    rd(12'h10, v); chk("R4 rising sets flag", v, 32'h2);
    irq_pin[0] = 1'b0;
    tick(3);
    rd(12'h10, v); chk("R7 two flags set", v, 32'h3);
    wr(12'h14, 32'h2);
    rd(12'h10, v); chk("R7 clear only bit1", v, 32'h1);
    wr(12'h14, 32'h1);
    rd(12'h10, v); chk("R7 clear bit0", v, 0);
    irq_pin[0] = 1'b1;
    tick(4);
  endtask

  task automatic t_both;
    logic [31:0] v;
    irq_pin[2] = 1'b0;
    tick(3);
    rd(12'h10, v); chk("R5 both mode on fall", v, 32'h4);
    wr(12'h14, 32'h4);
    irq_pin[2] = 1'b1;
    tick(3);
    rd(12'h10, v); chk("R5 both mode on rise", v, 32'h4);
    wr(12'h14, 32'h4);
    rd(12'h10, v); chk("R7 both cleared", v, 0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    irq_pin[3] = 1'b0;
    tick(3);
    rd(12'h10, v); chk("R6 low level sets flag", v, 32'h8);
    chk("R11 level output high", 32'(irq_out), 32'h8);
    wr(12'h14, 32'h8);
    tick(1);
    rd(12'h10, v); chk("R6 clear ignored in level mode", v, 32'h8);
    irq_pin[3] = 1'b1;
    tick(3);
    rd(12'h10, v); chk("R6 flag drops with pin", v, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    irq_pin[2] = 1'b0;
    tick(3);
    irq_pin[2] = 1'b1;
    tick(2);
    wr(12'h14, 32'h4);
    rd(12'h10, v); chk("R8 edge beats clear", v, 32'h4);
    wr(12'h14, 32'h4);
    rd(12'h10, v); chk("R8 later clear works", v, 0);
  endtask

  task automatic t_nmi;
    logic [31:0] v;
    nmi_pin = 1'b0;
    tick(3);
    rd(12'h00, v); chk("R9 nmi falling sets", v, 32'h1);
    chk("R11 nmi_out high", {31'd0, nmi_out}, 32'h1);
    wr(12'h04, 32'h1);
    rd(12'h00, v); chk("R10 nmi clear", v, 0);
    wr(12'h08, 32'h1);
    rd(12'h08, v); chk("R9 nmi sense readback", v, 32'h1);
    nmi_pin = 1'b1;
    tick(3);
    rd(12'h00, v); chk("R9 nmi rising sets", v, 32'h1);
    wr(12'h04, 32'h1);
    nmi_pin = 1'b0;
    tick(4);
    rd(12'h00, v); chk("R9 falling ignored in rise mode", v, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(12'h0C, 32'hFFFF_FFFF);
    wr(12'h1C, 32'hFFFF_FFFF);
    wr(12'h20, 32'hFFFF_FFFF);
    rd(12'h18, v); chk("R12 sense untouched", v, sense_exp);
    rd(12'h08, v); chk("R12 nmi sense untouched", v, 32'h1);
    rd(12'h1C, v); chk("R12 unmapped read zero", v, 0);
    rd(12'h0C, v); chk("R12 unmapped read zero 0C", v, 0);
  endtask

  initial begin
    t_reset;
    t_sense_regs;
    t_fall;
    t_rise;
    t_both;
    t_level;
    t_collide;
    t_nmi;
    t_unmapped;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired got=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule